// File: doc/BRIEF.md
# Seven-Segment Ring Rotation Sequencer

This block animates a single lit segment travelling around the outer ring of one common-cathode seven-segment digit. The six ring segments light one at a time, followed by a Blank frame with every segment dark, and the lap then repeats. The direction input picks clockwise or counter-clockwise travel. While the block is at rest the digit shows a fixed pattern: the middle bar alone is lit.

A one-cycle start/stop pulse seen at rest launches the animation at once. A later pulse does not halt the animation. It sets a one-bit stop request, and the block returns to rest only on the step taken out of the Blank frame. The current lap always finishes first. Steps advance on a one-clock-wide tick input, which a slow divider upstream supplies at the nominal 5 Hz rate. All other logic runs on the fast clock.

Top module: `rotseq_top`

## Requirements
- R1: While the active-low asynchronous reset is low, and in the first cycle after it is released, busy_o is 0 and seg_o is 7'b1000000. The bit order is {g,f,e,d,c,b,a} with bit 0 = a, and the outputs are active high.
- R2: At rest, with no start/stop pulse, the block stays at rest and keeps showing 7'b1000000 whatever tick_i and dir_i do.
- R3: A start/stop pulse at rest makes busy_o 1 on the next clock edge. seg_o then shows a (7'b0000001) when dir_i was 1, or f (7'b0100000) when dir_i was 0. This happens whether or not tick_i is high.
- R4: While running with dir_i = 1, each tick moves the frame a→b→c→d→e→f→Blank→a.
- R5: While running with dir_i = 0, each tick moves the frame f→e→d→c→b→a→Blank→f.
- R6: While running, a cycle without a tick leaves seg_o unchanged.
- R7: A start/stop pulse while running does not change the current frame. The block returns to rest on the first tick taken while the Blank frame is shown after that pulse, and only then.
- R8: With no stop request pending, a tick in the Blank frame starts the next lap: a for dir_i = 1, f for dir_i = 0.
- R9: A start/stop pulse in the same cycle as the transition to rest is ignored. The block stays at rest afterwards and no stop request survives into the next run.
- R10: busy_o is 1 exactly when the block is not at rest. While running, at most one segment is lit and g is never lit.
- R11: dir_i is sampled on every tick, so changing it in mid-lap reverses travel from the current frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Step enable, one clock wide, at the animation rate |
| ststp_i | input | 1 | Start/stop pulse, one clock wide, synchronous |
| dir_i | input | 1 | 1 = clockwise, 0 = counter-clockwise |
| seg_o | output | 7 | Segment lines {g,f,e,d,c,b,a}, active high |
| busy_o | output | 1 | High whenever the animation is running |

## Verification
The segment lines are decoded without any register from the phase and position state. A wrong position or phase therefore appears on seg_o and busy_o in the same cycle it is loaded, so the bench catches it at the next sample. A fault in the stop-request bit stays hidden until the next tick in the Blank frame. That can be up to a full lap of seven ticks later: the block then either leaves for rest too early or keeps looping. The bench compares against its model on every clock and forces this case at a known Blank step, so such a fault is seen no later than the end of the lap in progress.

// File: rtl/rotseq_pkg.sv
package rotseq_pkg;

   typedef enum logic {
      PH_REST = 1'b0,
      PH_RUN  = 1'b1
   } phase_e;

   // width of a position code able to hold RING_LEN frames plus Blank
   function automatic int unsigned pos_width(input int unsigned ring_len);
      return (ring_len < 2) ? 1 : $clog2(ring_len + 1);
   endfunction

endpackage

// File: rtl/rotseq_stop_mem.sv
module rotseq_stop_mem (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic req_o
);

   logic req_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         req_q <= 1'b0;
      end else if (clr_i) begin
         req_q <= 1'b0;
      end else if (set_i) begin
         req_q <= 1'b1;
      end
   end

   assign req_o = req_q;

endmodule

// File: rtl/rotseq_ring_ctr.sv
module rotseq_ring_ctr
   import rotseq_pkg::*;
#(
   parameter int unsigned RING_LEN = 6,
   localparam int unsigned PW = pos_width(RING_LEN)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          tick_i,
   input  logic          start_i,
   input  logic          dir_i,
   input  logic          req_i,
   output phase_e        phase_o,
   output logic [PW-1:0] pos_o,
   output logic          done_o
);

   localparam logic [PW-1:0] BLANK    = PW'(RING_LEN);
   localparam logic [PW-1:0] LAST_POS = PW'(RING_LEN - 1);
   localparam logic [PW-1:0] FIRST    = '0;

   phase_e        phase_q, phase_d;
   logic [PW-1:0] pos_q, pos_d;
   logic          running;
   logic          at_blank;
   logic [PW-1:0] pos_up, pos_dn;

   assign running  = (phase_q == PH_RUN);
   assign at_blank = (pos_q == BLANK);
   assign done_o   = running && tick_i && at_blank && req_i;

   // neighbour positions on the ring, Blank sitting between last and first
   assign pos_up = at_blank ? FIRST : pos_q + 1'b1;
   assign pos_dn = at_blank ? LAST_POS :
                   (pos_q == FIRST) ? BLANK : pos_q - 1'b1;

   always_comb begin
      phase_d = phase_q;
      pos_d   = pos_q;
      if (!running) begin
         if (start_i) begin
            phase_d = PH_RUN;
            pos_d   = dir_i ? FIRST : LAST_POS;
         end
      end else if (tick_i) begin
         if (done_o) begin
            phase_d = PH_REST;
            pos_d   = BLANK;
         end else begin
            pos_d = dir_i ? pos_up : pos_dn;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_REST;
         pos_q   <= BLANK;
      end else begin
         phase_q <= phase_d;
         pos_q   <= pos_d;
      end
   end

   assign phase_o = phase_q;
   assign pos_o   = pos_q;

endmodule

// File: rtl/rotseq_seg_dec.sv
module rotseq_seg_dec
   import rotseq_pkg::*;
#(
   parameter int unsigned RING_LEN     = 6,
   parameter bit          SEG_ACT_HIGH = 1'b1,
   localparam int unsigned PW    = pos_width(RING_LEN),
   localparam int unsigned SEG_W = RING_LEN + 1
) (
   input  phase_e           phase_i,
   input  logic [PW-1:0]    pos_i,
   output logic [SEG_W-1:0] seg_o
);

   logic [SEG_W-1:0] lit;
   logic             running;

   assign running = (phase_i == PH_RUN);

   for (genvar i = 0; i < RING_LEN; i++) begin : g_ring
      assign lit[i] = running && (pos_i == PW'(i));
   end

   // centre bar marks the rest pattern
   assign lit[SEG_W-1] = !running;

   if (SEG_ACT_HIGH) begin : g_pol_high
      assign seg_o = lit;
   end else begin : g_pol_low
      assign seg_o = ~lit;
   end

endmodule

// File: rtl/rotseq_top.sv
module rotseq_top
   import rotseq_pkg::*;
#(
   parameter int unsigned RING_LEN     = 6,
   parameter bit          SEG_ACT_HIGH = 1'b1,
   localparam int unsigned PW    = pos_width(RING_LEN),
   localparam int unsigned SEG_W = RING_LEN + 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             ststp_i,
   input  logic             dir_i,
   output logic [SEG_W-1:0] seg_o,
   output logic             busy_o
);

   if (RING_LEN < 2) begin : g_bad_ring
      $error("rotseq_top: RING_LEN must be at least 2");
   end
   if ((1 << PW) <= RING_LEN) begin : g_bad_pw
      $error("rotseq_top: position code too narrow");
   end

   phase_e        phase;
   logic [PW-1:0] pos;
   logic          done;
   logic          stop_req;
   logic          req_set;

   assign req_set = (phase == PH_RUN) && ststp_i && !done;

   rotseq_stop_mem u_stop (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (req_set),
      .clr_i  (done),
      .req_o  (stop_req)
   );

   rotseq_ring_ctr #(
      .RING_LEN (RING_LEN)
   ) u_ctr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .start_i (ststp_i),
      .dir_i   (dir_i),
      .req_i   (stop_req),
      .phase_o (phase),
      .pos_o   (pos),
      .done_o  (done)
   );

   rotseq_seg_dec #(
      .RING_LEN     (RING_LEN),
      .SEG_ACT_HIGH (SEG_ACT_HIGH)
   ) u_dec (
      .phase_i (phase),
      .pos_i   (pos),
      .seg_o   (seg_o)
   );

   assign busy_o = (phase == PH_RUN);

endmodule

// File: rtl/rotseq_chk.sv
module rotseq_chk #(
   parameter int unsigned RING_LEN     = 6,
   parameter bit          SEG_ACT_HIGH = 1'b1,
   localparam int unsigned SEG_W = RING_LEN + 1
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             tick_i,
   input logic             ststp_i,
   input logic             dir_i,
   input logic [SEG_W-1:0] seg_o,
   input logic             busy_o
);

   localparam logic [SEG_W-1:0] RING_MASK  = SEG_W'((1 << RING_LEN) - 1);
   localparam logic [SEG_W-1:0] REST_GLYPH = SEG_W'(1) << (SEG_W - 1);
   localparam logic [SEG_W-1:0] FIRST_CW   = SEG_W'(1);
   localparam logic [SEG_W-1:0] FIRST_CCW  = SEG_W'(1) << (RING_LEN - 1);

   logic [SEG_W-1:0] seg_n;
   assign seg_n = SEG_ACT_HIGH ? seg_o : ~seg_o;

   // R2
   rest_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && !ststp_i) |=> (!busy_o && seg_n == REST_GLYPH));

   // R3
   launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && ststp_i) |=>
         (busy_o && seg_n == ($past(dir_i) ? FIRST_CW : FIRST_CCW)));

   // R4
   cw_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && tick_i && dir_i && seg_n != '0) |=>
         (busy_o && seg_n == (($past(seg_n) << 1) & RING_MASK)));

   // R5
   ccw_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && tick_i && !dir_i && seg_n != '0) |=>
         (busy_o && seg_n == ($past(seg_n) >> 1)));

   // R6
   no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !tick_i) |=> (busy_o && $stable(seg_o)));

   // R7
   rest_from_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> ($past(seg_n) == '0 && $past(tick_i)));

   // R8
   new_lap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && tick_i && seg_n == '0) |=>
         (!busy_o || seg_n == ($past(dir_i) ? FIRST_CW : FIRST_CCW)));

   // R10
   run_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> ($countones(seg_n) <= 1 && !seg_n[SEG_W-1]));

   // R10
   rest_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> (seg_n == REST_GLYPH));

endmodule

bind rotseq_top rotseq_chk #(
   .RING_LEN     (RING_LEN),
   .SEG_ACT_HIGH (SEG_ACT_HIGH)
) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .tick_i  (tick_i),
   .ststp_i (ststp_i),
   .dir_i   (dir_i),
   .seg_o   (seg_o),
   .busy_o  (busy_o)
);

// File: tb/rotseq_top_test.sv
`timescale 1ns/1ps
module rotseq_top_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       ststp = 1'b0;
   logic       dir = 1'b1;
   logic [6:0] seg;
   logic       busy;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   // reference model state: run flag, position 0..5 ring, 6 = Blank, stop request
   int m_run = 0;
   int m_pos = 6;
   int m_req = 0;

   always #4 clk = ~clk;

   rotseq_top uut (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .tick_i  (tick),
      .ststp_i (ststp),
      .dir_i   (dir),
      .seg_o   (seg),
      .busy_o  (busy)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_run = 0; m_pos = 6; m_req = 0;
      end else if (m_run == 0) begin
         if (ststp) begin
            m_run = 1;
            m_pos = dir ? 0 : 5;
         end
      end else begin
         int leave;
         leave = (tick && m_pos == 6 && m_req) ? 1 : 0;
         if (ststp && !leave) m_req = 1;
         if (tick) begin
            if (leave) begin
               m_run = 0; m_pos = 6; m_req = 0;
            end else if (dir) begin
               m_pos = (m_pos + 1) % 7;
            end else begin
               m_pos = (m_pos + 6) % 7;
            end
         end
      end
   end

   function automatic logic [6:0] exp_seg();
      if (m_run == 0) return 7'b1000000;
      if (m_pos == 6) return 7'b0000000;
      return 7'(1 << m_pos);
   endfunction

   task automatic compare();
      checks++;
      if (seg !== exp_seg()) begin
         fails++;
         $display("FAIL %s seg actual=%b expected=%b at cycle %0d",
                  cur_req, seg, exp_seg(), cycles);
      end
      checks++;
      if (busy !== (m_run != 0)) begin
         fails++;
         $display("FAIL R10 busy actual=%b expected=%b at cycle %0d",
                  busy, (m_run != 0), cycles);
      end
   endtask

   task automatic step(input logic st, input logic d, input logic t);
      @(negedge clk);
      compare();
      ststp = st; dir = d; tick = t;
   endtask

   task automatic named(input string req, input logic cond, input string what);
      checks++;
      if (!cond) begin
         fails++;
         $display("FAIL %s %s", req, what);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000 && !done) begin
         done = 1'b1;
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      // R1: reset, asynchronous, then first cycle after release
      cur_req = "R1";
      repeat (3) begin
         @(negedge clk);
         compare();
      end
      rst_n = 1'b1;
      step(0, 1, 0);
      named("R1", seg == 7'b1000000 && !busy, "rest pattern after reset");

      // R2: rest ignores ticks and direction
      cur_req = "R2";
      for (int i = 0; i < 12; i++) step(0, i[1], i[0]);
      named("R2", seg == 7'b1000000 && !busy, "rest held under ticks");

      // R3: launch clockwise with tick high in the same cycle
      cur_req = "R3";
      step(1, 1, 1);
      step(0, 1, 0);
      named("R3", seg == 7'b0000001 && busy, "clockwise launch shows a");

      // R4 / R6 / R8: two full clockwise laps, ticks every third cycle
      cur_req = "R4";
      for (int i = 0; i < 42; i++) step(0, 1, (i % 3) == 2);
      cur_req = "R8";
      for (int i = 0; i < 10; i++) step(0, 1, (i % 2) == 1);
      cur_req = "R6";
      for (int i = 0; i < 15; i++) step(0, 1, 0);

      // R7: stop pulse mid-lap, twice, lap must finish before rest
      cur_req = "R7";
      step(1, 1, 0);
      step(0, 1, 1);
      step(1, 1, 0);
      named("R7", busy, "still running after stop pulse");
      for (int i = 0; i < 30 && m_run != 0; i++) step(0, 1, (i % 2) == 0);
      step(0, 1, 0);
      named("R7", !busy && seg == 7'b1000000, "rest reached after lap");

      // R5: counter-clockwise laps
      cur_req = "R5";
      step(1, 0, 0);
      step(0, 0, 0);
      named("R5", seg == 7'b0100000 && busy, "counter-clockwise launch shows f");
      for (int i = 0; i < 30; i++) step(0, 0, (i % 2) == 1);
      step(1, 0, 0);
      for (int i = 0; i < 30 && m_run != 0; i++) step(0, 0, 1);
      step(0, 0, 0);
      named("R5", !busy, "counter-clockwise stop reached rest");

      // R9: pulse coinciding with the return to rest
      cur_req = "R9";
      step(1, 1, 0);
      step(0, 1, 1);
      step(1, 1, 0);
      for (int i = 0; i < 20; i++) begin
         step(0, 1, 1);
         step(0, 1, 0);
         if (m_run != 0 && m_pos == 6) break;
      end
      step(1, 1, 1);
      for (int i = 0; i < 8; i++) step(0, 1, i[0]);
      named("R9", !busy && seg == 7'b1000000, "pulse at exit ignored");
      // next run must not carry a stale stop request through Blank
      step(1, 1, 0);
      for (int i = 0; i < 16; i++) step(0, 1, 1);
      named("R9", busy, "new run keeps looping past Blank");

      // R11: direction reversal mid-lap
      cur_req = "R11";
      step(0, 1, 1);
      step(0, 1, 1);
      for (int i = 0; i < 10; i++) step(0, 0, 1);
      for (int i = 0; i < 5; i++) step(0, 1, 1);
      // mixed pseudo-random traffic
      for (int i = 0; i < 3000; i++) begin
         logic st, t, d;
         st = (($urandom % 23) == 0);
         t  = (($urandom % 3) == 0);
         d  = (($urandom % 40) == 0) ? ~dir : dir;
         step(st, d, t);
      end
      step(0, dir, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule